// File: doc/BRIEF.md
# Transactional Commit Sequencer

This block sits beside one core's private cache and handles the core's side of failure-atomic transactions. When a transaction opens, the block builds a transaction tag from the thread number and a per-thread serial count. Stores made while the transaction is open are labelled with that tag. Each store also marks its cache line in a dirty bitmap. A marked line that leaves the cache through eviction or a coherence request is written back with the tag, and its mark is then cleared.

Commit is a two-phase exchange:

- The core is stalled until the store buffer reports empty.
- The bitmap is walked and every marked line is written back, one per cycle at most.
- An outstanding-acknowledgement counter must reach zero before a single commit request, carrying the tag, is broadcast to all memory controllers.
- The stall is lifted only once every controller has confirmed.

A context switch flushes the marked lines without committing and discards the bitmap.

Top module: `txn_commit_seq`

## Requirements
- R1: Each accepted begin loads the tag as {thread_id, serial}, with thread_id in the upper bits, and then increments the SERIAL_W-bit serial modulo 2^SERIAL_W. A begin is accepted only when no transaction is open and no commit is running.
- R2: While a transaction is open (txn_active=1), a store sets the bitmap bit of its line and store_tag shows the current tag. A store made while no transaction is open marks nothing.
- R3: While a transaction is open, an evict request for a marked line raises wb_valid with that line and the tag. The mark clears when the handshake completes. An evict request for an unmarked line raises no writeback.
- R4: A commit request raises stall on the next cycle. No writeback is issued until sb_drained has been seen high.
- R5: The commit walk issues writebacks lowest line index first, at most one per cycle. Each one holds wb_valid and wb_line steady until wb_ready.
- R6: The outstanding count rises on each accepted writeback and falls on each mem_ack. cmt_valid never rises while any writeback is unacknowledged.
- R7: After the walk ends and the count is zero, cmt_valid pulses for exactly one cycle, with cmt_tag equal to the transaction tag.
- R8: stall stays high until all NUM_MC bits of cmt_ack have been seen. Acknowledgements may arrive in any order, and a repeat of one already received has no effect.
- R9: A context switch stalls the core and writes back every marked line, lowest first. It then releases the stall with the transaction still open and the bitmap empty, so a following commit issues no writebacks.
- R10: A begin raised during a commit is held. When the commit completes, the new transaction opens with a fresh tag and no second begin is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_id | input | THREAD_W | Running thread number |
| begin_req | input | 1 | Open a transaction |
| commit_req | input | 1 | Commit the open transaction |
| ctx_switch | input | 1 | Flush marked lines without committing |
| sb_drained | input | 1 | Store buffer is empty |
| store_valid | input | 1 | Store strobe |
| store_line | input | IDX_W | Line index of the store |
| evict_valid | input | 1 | Line is leaving the cache; held until written back or seen unmarked |
| evict_line | input | IDX_W | Line index of the eviction |
| store_tag | output | TID_W | Tag attached to outgoing stores |
| txn_active | output | 1 | A transaction is open and not committing |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_line | output | IDX_W | Line to write back |
| wb_tag | output | TID_W | Tag carried by the writeback |
| mem_ack | input | 1 | One writeback acknowledged by memory |
| cmt_valid | output | 1 | Commit broadcast pulse |
| cmt_tag | output | TID_W | Tag being committed |
| cmt_ack | input | NUM_MC | Per-controller commit confirmation |
| stall | output | 1 | Hold the core pipeline |

## Verification
The hardest case to reach is a commit broadcast racing its own preconditions. The stimulus has to create the last outstanding write acknowledgement, a stalled writeback port and a begin that arrives mid-commit all in one run. The bench sweeps every bitmap pattern of an eight-line configuration, throttling wb_ready on every third pattern. It trickles memory acknowledgements and checks cmt_valid stays low until the last one. Commit confirmations arrive in a rotating order with one deliberate repeat, and on some patterns a begin is injected during the confirmation phase.

// File: rtl/txn_commit_seq.sv
module txn_commit_seq #(
  parameter int THREAD_W = 8,
  parameter int SERIAL_W = 16,
  parameter int LINES    = 64,
  parameter int NUM_MC   = 4,
  parameter int ACK_W    = 8,
  localparam int IDX_W   = $clog2(LINES),
  localparam int TID_W   = THREAD_W + SERIAL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [THREAD_W-1:0] thread_id,
  input  logic                begin_req,
  input  logic                commit_req,
  input  logic                ctx_switch,
  input  logic                sb_drained,
  input  logic                store_valid,
  input  logic [IDX_W-1:0]    store_line,
  input  logic                evict_valid,
  input  logic [IDX_W-1:0]    evict_line,
  output logic [TID_W-1:0]    store_tag,
  output logic                txn_active,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [IDX_W-1:0]    wb_line,
  output logic [TID_W-1:0]    wb_tag,
  input  logic                mem_ack,
  output logic                cmt_valid,
  output logic [TID_W-1:0]    cmt_tag,
  input  logic [NUM_MC-1:0]   cmt_ack,
  output logic                stall
);

  typedef enum logic [2:0] {IDLE, OPEN, DRAIN, WALK, WAITACK, CSEND, CWAIT, FLUSH} st_t;

  st_t                 state;
  logic [SERIAL_W-1:0] serial;
  logic [TID_W-1:0]    tid;
  logic [LINES-1:0]    dirty;
  logic [ACK_W-1:0]    pend;
  logic [NUM_MC-1:0]   got;
  logic                begin_held;
  logic [IDX_W-1:0]    low_idx;

  wire walking  = (state == WALK) || (state == FLUSH);
  wire mask_nxt = &(got | cmt_ack);
  wire done     = (state == CWAIT || state == CSEND) && mask_nxt;
  wire start    = (state == IDLE && begin_req) || (done && (begin_held || begin_req));
  wire wb_fire  = wb_valid && wb_ready;

  always_comb begin
    low_idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (dirty[i]) low_idx = IDX_W'(i);
  end

  assign wb_valid   = walking ? |dirty : (state == OPEN && evict_valid && dirty[evict_line]);
  assign wb_line    = walking ? low_idx : evict_line;
  assign wb_tag     = tid;
  assign store_tag  = tid;
  assign cmt_tag    = tid;
  assign cmt_valid  = (state == CSEND);
  assign txn_active = (state == OPEN);
  assign stall      = !(state == IDLE || state == OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      serial     <= '0;
      tid        <= '0;
      dirty      <= '0;
      pend       <= '0;
      got        <= '0;
      begin_held <= 1'b0;
    end else begin
      if (wb_fire && !mem_ack)      pend <= pend + 1'b1;
      else if (!wb_fire && mem_ack) pend <= pend - 1'b1;

      if (wb_fire) dirty[wb_line] <= 1'b0;
      if (state == OPEN && store_valid) dirty[store_line] <= 1'b1;

      if (start) begin
        tid        <= {thread_id, serial};
        serial     <= serial + 1'b1;
        begin_held <= 1'b0;
      end else if (begin_req && stall) begin
        begin_held <= 1'b1;
      end

      case (state)
        IDLE:    if (begin_req) state <= OPEN;
        OPEN:    if (commit_req) state <= DRAIN;
                 else if (ctx_switch) state <= FLUSH;
        DRAIN:   if (sb_drained) state <= WALK;
        WALK:    if (dirty == '0) state <= WAITACK;
        FLUSH:   if (dirty == '0) state <= OPEN;
        WAITACK: if (pend == '0) state <= CSEND;
        CSEND, CWAIT: begin
          if (done) begin
            got   <= '0;
            state <= start ? OPEN : IDLE;
          end else begin
            got   <= got | cmt_ack;
            state <= CWAIT;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_serial_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> serial == $past(serial) + 1'b1);
  assert_mark_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && !(state == OPEN && store_valid && store_line == wb_line)) |=> !dirty[$past(wb_line)]);
  assert_no_wb_undrained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DRAIN) |-> !wb_valid);
  assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && wb_valid && !wb_ready) |=> wb_valid && $stable(wb_line));
  assert_cmt_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> pend == '0 && dirty == '0);
  assert_ack_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> (pend != '0 || wb_fire));
  assert_cmt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> !cmt_valid && stall);
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CWAIT && !mask_nxt) |=> stall);
endmodule

// File: tb/txn_commit_seq_test.sv
module txn_commit_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int THREAD_W = 2;
  localparam int SERIAL_W = 3;
  localparam int LINES = 8;
  localparam int NUM_MC = 4;
  localparam int IDX_W = 3;
  localparam int TID_W = THREAD_W + SERIAL_W;

  logic clk = 0, rst_n = 0;
  logic [THREAD_W-1:0] thread_id = '0;
  logic begin_req = 0, commit_req = 0, ctx_switch = 0, sb_drained = 0;
  logic store_valid = 0, evict_valid = 0, wb_ready = 0, mem_ack = 0;
  logic [IDX_W-1:0] store_line = '0, evict_line = '0;
  logic [NUM_MC-1:0] cmt_ack = '0;
  logic [TID_W-1:0] store_tag, wb_tag, cmt_tag;
  logic [IDX_W-1:0] wb_line;
  logic txn_active, wb_valid, cmt_valid, stall;

  int checks = 0, fails = 0;
  int ser = 0;
  logic [TID_W-1:0] exp_tid = '0;
  bit open_already = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_commit_seq #(.THREAD_W(THREAD_W), .SERIAL_W(SERIAL_W), .LINES(LINES),
                   .NUM_MC(NUM_MC), .ACK_W(6)) uut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_txn(input int t);
    thread_id = THREAD_W'(t); begin_req = 1; tick(); begin_req = 0;
    exp_tid = TID_W'((t << SERIAL_W) | ser); ser = (ser + 1) % (1 << SERIAL_W);
    chk(store_tag == exp_tid, "R1", store_tag, exp_tid);
    chk(txn_active == 1, "R1", txn_active, 1);
  endtask

  task automatic store_lines(input logic [LINES-1:0] m);
    for (int i = 0; i < LINES; i++) if (m[i]) begin
      store_valid = 1; store_line = IDX_W'(i);
      chk(store_tag == exp_tid, "R2", store_tag, exp_tid);
      tick();
    end
    store_valid = 0;
  endtask

  task automatic walk(input logic [LINES-1:0] m, input bit throttle, input string req);
    int cyc = 0;
    logic [LINES-1:0] left = m;
    while (left != 0 && cyc < 100) begin
      wb_ready = throttle ? cyc[0] : 1'b1;
      if (wb_valid && wb_ready) begin
        int e = 0;
        for (int i = LINES - 1; i >= 0; i--) if (left[i]) e = i;
        chk(wb_line == IDX_W'(e), req, wb_line, e);
        chk(wb_tag == exp_tid, req, wb_tag, exp_tid);
        left[e] = 0;
      end
      tick(); cyc++;
    end
    wb_ready = 0;
    chk(left == 0, req, left, 0);
  endtask

  task automatic acks(input int n);
    for (int k = 0; k < n; k++) begin
      chk(cmt_valid == 0, "R6", cmt_valid, 0);
      mem_ack = 1; tick(); mem_ack = 0;
      chk(cmt_valid == 0, "R6", cmt_valid, 0);
      tick();
    end
  endtask

  task automatic commit(input logic [LINES-1:0] m, input bit throttle, input bit late_begin, input int rot);
    int w = 0;
    commit_req = 1; tick(); commit_req = 0;
    chk(stall == 1, "R4", stall, 1);
    tick(); chk(wb_valid == 0, "R4", wb_valid, 0);
    tick(); chk(wb_valid == 0, "R4", wb_valid, 0);
    sb_drained = 1; tick(); sb_drained = 0;
    walk(m, throttle, "R5");
    acks($countones(m));
    while (!cmt_valid && w < 5) begin tick(); w++; end
    chk(cmt_valid == 1, "R7", cmt_valid, 1);
    chk(cmt_tag == exp_tid, "R7", cmt_tag, exp_tid);
    for (int j = 0; j < NUM_MC; j++) begin
      cmt_ack = NUM_MC'(1 << ((j + rot) % NUM_MC));
      if (late_begin && j == 1) begin_req = 1;
      tick(); cmt_ack = '0; begin_req = 0;
      if (j == 0) chk(cmt_valid == 0, "R7", cmt_valid, 0);
      if (j < NUM_MC - 1) chk(stall == 1, "R8", stall, 1);
      if (j == 1) begin
        cmt_ack = NUM_MC'(1 << ((1 + rot) % NUM_MC)); tick(); cmt_ack = '0;
        chk(stall == 1, "R8", stall, 1);
      end
    end
    chk(stall == 0, "R8", stall, 0);
    if (late_begin) begin
      exp_tid = TID_W'((int'(thread_id) << SERIAL_W) | ser); ser = (ser + 1) % (1 << SERIAL_W);
      chk(txn_active == 1, "R10", txn_active, 1);
      chk(store_tag == exp_tid, "R10", store_tag, exp_tid);
    end else begin
      chk(txn_active == 0, "R8", txn_active, 0);
    end
    open_already = late_begin;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(stall == 0 && wb_valid == 0 && cmt_valid == 0 && txn_active == 0, "R1", stall, 0);
    rst_n = 1; tick();

    // R2: store with no open transaction marks nothing
    store_valid = 1; store_line = 3'd7; tick(); store_valid = 0;
    open_txn(1);
    commit('0, 0, 0, 0);

    // R3: eviction of marked and unmarked lines
    open_txn(2);
    store_lines(8'b0010_0100);
    evict_valid = 1; evict_line = 3'd4; #1;
    chk(wb_valid == 0, "R3", wb_valid, 0);
    tick();
    chk(wb_valid == 0, "R3", wb_valid, 0);
    evict_line = 3'd5; #1;
    chk(wb_valid == 1 && wb_line == 3'd5, "R3", wb_line, 5);
    chk(wb_tag == exp_tid, "R3", wb_tag, exp_tid);
    wb_ready = 1; tick(); wb_ready = 0; evict_valid = 0;
    chk(wb_valid == 0, "R3", wb_valid, 0);
    acks(1);
    commit(8'b0000_0100, 0, 0, 1);

    // R9: context switch flush keeps the transaction open
    open_txn(3);
    store_lines(8'b0100_1010);
    ctx_switch = 1; tick(); ctx_switch = 0;
    chk(stall == 1, "R9", stall, 1);
    walk(8'b0100_1010, 1, "R9");
    tick();
    chk(stall == 0 && txn_active == 1, "R9", stall, 0);
    acks(3);
    commit('0, 0, 0, 2);

    // R1 R5 R6 R7 R8 R10: sweep every bitmap pattern
    for (int p = 0; p < 256; p++) begin
      if (!open_already) open_txn(p % 4);
      store_lines(LINES'(p));
      commit(LINES'(p), (p % 3) == 1, (p % 16) == 5, p % NUM_MC);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule